// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one `WIDTH`-bit integer by another over several clock cycles. It returns a `WIDTH`-bit quotient and a `WIDTH`-bit remainder. The work is long division in restoring form, with one trial subtraction per cycle.

At the start, a double-width working register holds the dividend magnitude. A double-width divisor register holds the divisor magnitude in its upper half. Each step subtracts the divisor from the remainder. A negative result puts the old remainder back and shifts a 0 into the quotient. A non-negative result keeps the difference and shifts in a 1. The divisor register then moves right by one place. After `WIDTH+1` steps, a final cycle corrects the signs and writes the results.

A caller pulses `start` with the operands and the `signedMode` choice. The caller watches `busy`, then reads the result when `done` pulses. In signed mode the block divides magnitudes and then fixes the signs. A zero divisor skips the iterations. It raises a flag and returns fixed values; no trap is raised.

Top module: `seqDivider`

## Requirements
- R1: With `signedMode`=0, operands are unsigned, and the outputs give quotient = floor(dividend/divisor) and remainder = dividend − quotient·divisor.
- R2: With `signedMode`=1, operands are two's complement. The quotient is truncated toward zero and is negated when the operand signs differ. The remainder takes the sign of the dividend. The quotient wraps modulo 2^WIDTH, so the most negative value divided by −1 gives the most negative value.
- R3: A zero divisor sets `divByZero`=1, `quotient` to all ones and `remainder` to the raw dividend. `done` rises on the 2nd rising edge, counting the edge that captures `start` as the 1st. A later division with a non-zero divisor returns `divByZero` to 0.
- R4: With a non-zero divisor, `done` rises on rising edge WIDTH+3, counting the start-capturing edge as edge 1. That count covers one load edge, WIDTH+1 subtract steps and one sign-fix edge.
- R5: `done` is high for exactly one cycle per division. `busy` is high from the edge that captures `start` until the edge that raises `done`, and it is low while `done` is high.
- R6: `start` has no effect while `busy` is high. The running division completes with its original operands and original latency.
- R7: After reset, `busy`, `done`, `divByZero`, `quotient` and `remainder` are all 0.
- R8: `quotient`, `remainder` and `divByZero` change only on the edge that raises `done`. They hold their values between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division when idle |
| signedMode | input | 1 | 1: two's complement operands, 0: unsigned |
| dividend | input | WIDTH | Dividend, sampled with start |
| divisor | input | WIDTH | Divisor, sampled with start |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when results are written |
| quotient | output | WIDTH | Quotient (low half of the result pair) |
| remainder | output | WIDTH | Remainder (high half of the result pair) |
| divByZero | output | 1 | Last result came from a zero divisor |

## Verification
The hardest states to reach are the signed-magnitude corners. A most-negative dividend has a magnitude that only just fits in WIDTH bits. Dividing it by −1 overflows the quotient back to itself. The vector table drives 0x80/0xFF and 0x80/3 next to the mixed-sign cases, so the negation and wrap paths are both exercised. A second new `start` is injected in the middle of a running division with different operands, and both the result and the edge count are checked. The bench also runs a zero-divisor case right before a normal case, to check that the flag clears.

// File: rtl/divPkg.sv
package divPkg;
  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } divCtrlT;
endpackage

// File: rtl/divControl.sv
module divControl
  import divPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    divisorZero,
  output divCtrlT ctrl,
  output logic    busy,
  output logic    done
);
  localparam int CNTW = $clog2(WIDTH + 1) + 1;
  localparam logic [CNTW-1:0] LAST_STEP = CNTW'(WIDTH);

  typedef enum logic [1:0] {IDLE, RUN, FINISH} stateT;
  stateT state;
  logic [CNTW-1:0] stepCnt;
  logic doneReg;

  always_comb begin
    ctrl.load   = (state == IDLE) && start;
    ctrl.step   = (state == RUN);
    ctrl.finish = (state == FINISH);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= IDLE;
      stepCnt <= '0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      case (state)
        IDLE: if (start) begin
          stepCnt <= '0;
          state   <= divisorZero ? FINISH : RUN;
        end
        RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST_STEP) state <= FINISH;
        end
        FINISH: begin
          doneReg <= 1'b1;
          state   <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end

  assign busy = (state != IDLE);
  assign done = doneReg;

  // R5: done lasts one cycle
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R5: busy and done never overlap
  assert_busy_done_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));
  // R4: each running cycle advances the step counter or leaves for the fix-up cycle
  assert_step_advance_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == RUN) |=> ((state == RUN) && (stepCnt == $past(stepCnt) + 1'b1)) || (state == FINISH));
  // R6: a start while busy does not restart the count
  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == RUN && start && stepCnt != LAST_STEP) |=> (state == RUN) && (stepCnt != '0));
endmodule

// File: rtl/divDatapath.sv
module divDatapath
  import divPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  divCtrlT          ctrl,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             divisorZero,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             divByZero
);
  localparam int DW = 2 * WIDTH;

  logic [DW-1:0]    remReg, divReg;
  logic [WIDTH-1:0] quoReg, rawDividend, divMag;
  logic             negQuo, negRem, zeroLatched;
  logic             aNeg, bNeg;
  logic [WIDTH-1:0] aMag, bMag;
  logic [DW:0]      trialDiff;
  logic [WIDTH-1:0] remLow;

  assign divisorZero = (divisor == '0);

  always_comb begin
    aNeg = signedMode && dividend[WIDTH-1];
    bNeg = signedMode && divisor[WIDTH-1];
    aMag = aNeg ? (~dividend + 1'b1) : dividend;
    bMag = bNeg ? (~divisor + 1'b1) : divisor;
    trialDiff = {1'b0, remReg} - {1'b0, divReg};
    remLow = remReg[WIDTH-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remReg      <= '0;
      divReg      <= '0;
      quoReg      <= '0;
      rawDividend <= '0;
      divMag      <= '0;
      negQuo      <= 1'b0;
      negRem      <= 1'b0;
      zeroLatched <= 1'b0;
      quotient    <= '0;
      remainder   <= '0;
      divByZero   <= 1'b0;
    end else begin
      if (ctrl.load) begin
        remReg      <= {{WIDTH{1'b0}}, aMag};
        divReg      <= {bMag, {WIDTH{1'b0}}};
        quoReg      <= '0;
        rawDividend <= dividend;
        divMag      <= bMag;
        negQuo      <= aNeg ^ bNeg;
        negRem      <= aNeg;
        zeroLatched <= divisorZero;
      end else if (ctrl.step) begin
        if (trialDiff[DW]) begin
          quoReg <= {quoReg[WIDTH-2:0], 1'b0};
        end else begin
          remReg <= trialDiff[DW-1:0];
          quoReg <= {quoReg[WIDTH-2:0], 1'b1};
        end
        divReg <= divReg >> 1;
      end else if (ctrl.finish) begin
        divByZero <= zeroLatched;
        if (zeroLatched) begin
          quotient  <= '1;
          remainder <= rawDividend;
        end else begin
          quotient  <= negQuo ? (~quoReg + 1'b1) : quoReg;
          remainder <= negRem ? (~remLow + 1'b1) : remLow;
        end
      end
    end
  end

  // R1: at fix-up, the remainder magnitude is below the divisor magnitude
  assert_rem_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.finish && !zeroLatched) |-> (remReg[DW-1:WIDTH] == '0) && (remLow < divMag));
  // R8: results move only on the fix-up edge
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.finish |=> $stable(quotient) && $stable(remainder) && $stable(divByZero));
  // R3: a zero-divisor result carries all-ones quotient and the raw dividend
  assert_zero_result_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.finish && zeroLatched) |=> divByZero && (quotient == '1) && (remainder == $past(rawDividend)));
endmodule

// File: rtl/seqDivider.sv
module seqDivider
  import divPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             divByZero
);
  divCtrlT ctrl;
  logic    divisorZero;

  divControl #(.WIDTH(WIDTH)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .divisorZero(divisorZero),
    .ctrl(ctrl), .busy(busy), .done(done)
  );

  divDatapath #(.WIDTH(WIDTH)) uPath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .signedMode(signedMode),
    .dividend(dividend), .divisor(divisor), .divisorZero(divisorZero),
    .quotient(quotient), .remainder(remainder), .divByZero(divByZero)
  );
endmodule

// File: tb/tb_seqDivider.sv
module tb_seqDivider;
  localparam int W = 8;
  localparam int NV = 12;
  localparam int LAT = W + 3;

  // {signedMode, dividend, divisor, quotient, remainder}
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 8'd7,   8'd2,   8'd3,   8'd1},
    {1'b0, 8'd200, 8'd7,   8'd28,  8'd4},
    {1'b0, 8'd255, 8'd1,   8'd255, 8'd0},
    {1'b0, 8'd5,   8'd9,   8'd0,   8'd5},
    {1'b0, 8'd255, 8'd255, 8'd1,   8'd0},
    {1'b0, 8'd128, 8'd16,  8'd8,   8'd0},
    {1'b1, 8'hF9,  8'h02,  8'hFD,  8'hFF},
    {1'b1, 8'h07,  8'hFE,  8'hFD,  8'h01},
    {1'b1, 8'hF9,  8'hFE,  8'h03,  8'hFF},
    {1'b1, 8'h80,  8'hFF,  8'h80,  8'h00},
    {1'b1, 8'h80,  8'h03,  8'hD6,  8'hFE},
    {1'b1, 8'd100, 8'd7,   8'd14,  8'd2}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic signedMode = 1'b0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic busy, done, divByZero;
  logic [W-1:0] quotient, remainder;
  int total = 0;
  int bad = 0;
  int lat;

  always #4 clk = ~clk;

  seqDivider #(.WIDTH(W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .signedMode(signedMode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder), .divByZero(divByZero)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // starts a division at a negedge; returns the edge count until done
  task automatic runDiv(input logic sm, input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit poke, output int edges);
    signedMode = sm; dividend = a; divisor = b; start = 1'b1;
    @(negedge clk);
    edges = 1;
    start = 1'b0;
    check(busy == 1'b1, "R5 busy after start", busy, 1);
    if (poke) begin
      @(negedge clk); edges++;
      signedMode = ~sm; dividend = 8'd250; divisor = 8'd3; start = 1'b1;
      @(negedge clk); edges++;
      start = 1'b0;
    end
    while (!done && edges < 100) begin
      @(negedge clk); edges++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state
    check(busy == 0 && done == 0 && divByZero == 0, "R7 flags", {busy, done, divByZero}, 0);
    check(quotient == 0 && remainder == 0, "R7 results", {quotient, remainder}, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      runDiv(VEC[i][32], VEC[i][31:24], VEC[i][23:16], 1'b0, lat);
      // R1 unsigned rows 0..5, R2 signed rows 6..11
      check(quotient == VEC[i][15:8], VEC[i][32] ? "R2 quotient" : "R1 quotient",
            quotient, VEC[i][15:8]);
      check(remainder == VEC[i][7:0], VEC[i][32] ? "R2 remainder" : "R1 remainder",
            remainder, VEC[i][7:0]);
      check(divByZero == 0, "R3 flag low", divByZero, 0);
      check(lat == LAT, "R4 latency", lat, LAT);
      check(busy == 0, "R5 busy low at done", busy, 0);
      @(negedge clk);
      check(done == 0, "R5 single pulse", done, 1'b0);
    end

    // R3 zero divisor, unsigned
    runDiv(1'b0, 8'h5A, 8'h00, 1'b0, lat);
    check(divByZero == 1, "R3 flag", divByZero, 1);
    check(quotient == 8'hFF, "R3 quotient", quotient, 8'hFF);
    check(remainder == 8'h5A, "R3 remainder", remainder, 8'h5A);
    check(lat == 2, "R3 latency", lat, 2);
    // R8 hold between results
    repeat (5) @(negedge clk);
    check(quotient == 8'hFF && remainder == 8'h5A && divByZero == 1, "R8 hold",
          {quotient, remainder}, 16'hFF5A);
    // R3 zero divisor, signed mode keeps raw dividend
    runDiv(1'b1, 8'h80, 8'h00, 1'b0, lat);
    check(quotient == 8'hFF && remainder == 8'h80, "R3 signed zero",
          {quotient, remainder}, 16'hFF80);
    @(negedge clk);
    // R3 flag clears on the next normal division
    runDiv(1'b0, 8'd9, 8'd4, 1'b0, lat);
    check(divByZero == 0 && quotient == 8'd2 && remainder == 8'd1, "R3 flag clears",
          {divByZero, quotient, remainder}, {1'b0, 8'd2, 8'd1});

    // R6 start while busy is ignored
    @(negedge clk);
    runDiv(1'b0, 8'd100, 8'd9, 1'b1, lat);
    check(quotient == 8'd11 && remainder == 8'd1, "R6 result",
          {quotient, remainder}, {8'd11, 8'd1});
    check(lat == LAT, "R6 latency", lat, LAT);
    @(negedge clk);
    check(busy == 0 && done == 0, "R6 no restart", {busy, done}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule